// File: doc/BRIEF.md
# CPU Bus Isolation and Parallel Port Adapter

This block sits in programmable logic between a stock 8-bit microprocessor core and the system bus of its host. It passes the core's address, write data and read/write strobe to the system side and releases all three when the address-enable control input `aec` goes low, so that a second bus master, such as a video controller, can use the bus without contention. The read/write strobe goes through a transparent latch gated by the external `gate` input. The latch follows the core while `gate` is high and keeps its last value while `gate` is low.

The block also decodes the two lowest core addresses to emulate an on-chip parallel port. Address 0x0000 holds the direction register and address 0x0001 holds the value register. The port has pins 0 to 4, 6 and 7. Pin 5 is absent, so bits 6 and 7 remain directly testable with bit-test instructions. The clock input is the core's phase-2 clock. Port registers load on its falling edge.

The interfaces are plain, level-driven bus pins with no valid/ready handshake. A bus cycle lasts one phase-2 period, and the host applies back-pressure only by stretching or stopping that clock.

Top module: `cpu_bus_adapter`

## Requirements
- R1: While `rst_n` is low, both port registers clear to zero, so every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: `sys_addr_o` always equals `core_addr`. `sys_addr_oe` is 1 exactly when `aec` is 1.
- R3: `sys_data_o` always equals `core_dout`. `sys_data_oe` is 1 only when `aec` is 1 and `core_rw` is 0 (write).
- R4: `sys_rw_o` follows `core_rw` while `gate` is 1. It holds its last value while `gate` is 0, whatever `core_rw` does.
- R5: `sys_rw_oe` is 1 exactly when `aec` is 1. When enabled, the strobe driven is the latched value from R4.
- R6: A write cycle (`core_rw`=0) to address 0x0000 loads the direction register on the falling edge of `clk`. `pin_oe` equals the direction register. Bit 5 is never stored and always reads 0.
- R7: A write cycle to address 0x0001 loads the value register on the falling edge of `clk`. `pin_out` equals the value register, with bit 5 held at 0.
- R8: A read cycle (`core_rw`=1) at 0x0000 returns the direction register on `core_din`, with bit 5 as 0.
- R9: A read cycle at 0x0001 returns the value register on bits whose direction bit is 1 and `pin_in` on bits whose direction bit is 0. Bit 5 reads 0.
- R10: A read cycle at any other address returns `sys_data_i` on `core_din`. During write cycles `core_din` is 0.
- R11: Port register writes are still presented to the system bus: the address, the data and an asserted `sys_data_oe` appear when `aec` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core phase-2 clock; port registers load on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_addr | input | 16 | Address from the core |
| core_dout | input | 8 | Write data from the core |
| core_din | output | 8 | Read data to the core |
| core_rw | input | 1 | Core strobe, 1 = read, 0 = write |
| aec | input | 1 | Address-enable control, 0 releases the system bus |
| gate | input | 1 | Read/write latch gate, 1 = transparent |
| sys_addr_o | output | 16 | System address value |
| sys_addr_oe | output | 1 | System address drive enable |
| sys_data_o | output | 8 | System write data value |
| sys_data_oe | output | 1 | System data drive enable |
| sys_data_i | input | 8 | System read data |
| sys_rw_o | output | 1 | Latched read/write strobe |
| sys_rw_oe | output | 1 | Read/write strobe drive enable |
| pin_in | input | 8 | Port pin levels |
| pin_out | output | 8 | Port pin output values |
| pin_oe | output | 8 | Port pin output enables |

## Verification
The bench runs bus cycles with `aec` high and low, crossed with read and write, so that the drive enables for address, data and strobe can each be told apart from the others. It toggles `core_rw` while `gate` is low to separate a held latch from a transparent one. Port cycles write the value 0xFF, alternating patterns and 0x00 to the direction and value registers, and then read back with differing `pin_in`. This shows whether each bit is taken from the register or from the pin, and whether bit 5 stays 0. Reads at addresses 0x0002 and 0x0100 check that the decoder does not alias, and a port write with `aec` high shows that the write also reaches the system bus.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_VAL  = 2'd2
  } port_sel_e;

  function automatic port_sel_e decode_port(input logic [15:0] addr,
                                            input logic [15:0] dir_addr,
                                            input logic [15:0] val_addr);
    if (addr == dir_addr)      return SEL_DIR;
    else if (addr == val_addr) return SEL_VAL;
    else                       return SEL_NONE;
  endfunction
endpackage

// File: rtl/rw_hold_latch.sv
module rw_hold_latch (
  input  logic gate,
  input  logic d,
  output logic q
);
  always_latch begin
    if (gate) q <= d;
  end
endmodule

// File: rtl/bus_gate.sv
module bus_gate #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              aec,
  input  logic              core_rw,
  input  logic              rw_held,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_dout,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic              sys_addr_oe,
  output logic [DATA_W-1:0] sys_data_o,
  output logic              sys_data_oe,
  output logic              sys_rw_o,
  output logic              sys_rw_oe
);
  always_comb begin
    sys_addr_o  = core_addr;
    sys_addr_oe = aec;
    sys_data_o  = core_dout;
    sys_data_oe = aec & ~core_rw;
    sys_rw_o    = rw_held;
    sys_rw_oe   = aec;
  end
endmodule

// File: rtl/io_port_regs.sv
module io_port_regs #(
  parameter int          WIDTH = 8,
  parameter logic [7:0]  MASK  = 8'hDF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_val,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rd_dir,
  output logic [WIDTH-1:0] rd_val,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] val_q;
  logic             unused_masked;

  assign unused_masked = ^((wdata | pin_in) & ~MASK[WIDTH-1:0]);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (MASK[i]) begin : g_present
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_q[i] <= 1'b0;
          val_q[i] <= 1'b0;
        end else begin
          if (wr_dir) dir_q[i] <= wdata[i];
          if (wr_val) val_q[i] <= wdata[i];
        end
      end
      assign rd_val[i] = dir_q[i] ? val_q[i] : pin_in[i];
    end else begin : g_absent
      assign dir_q[i]  = 1'b0;
      assign val_q[i]  = 1'b0;
      assign rd_val[i] = 1'b0;
    end
  end

  assign rd_dir  = dir_q;
  assign pin_out = val_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/cpu_bus_adapter.sv
module cpu_bus_adapter #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  PIN_MASK = 8'hDF,
  parameter logic [15:0] DIR_ADDR = 16'h0000,
  parameter logic [15:0] VAL_ADDR = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_dout,
  output logic [DATA_W-1:0] core_din,
  input  logic              core_rw,
  input  logic              aec,
  input  logic              gate,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic              sys_addr_oe,
  output logic [DATA_W-1:0] sys_data_o,
  output logic              sys_data_oe,
  input  logic [DATA_W-1:0] sys_data_i,
  output logic              sys_rw_o,
  output logic              sys_rw_oe,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  import cpu_bus_pkg::*;

  port_sel_e        sel;
  logic             rw_held;
  logic             wr_dir, wr_val;
  logic [DATA_W-1:0] rd_dir, rd_val;
  logic [15:0]      addr_ext;

  if (ADDR_W >= 16) begin : g_addr_wide
    assign addr_ext = core_addr[15:0];
    logic unused_hi;
    if (ADDR_W > 16) begin : g_hi
      assign unused_hi = |core_addr[ADDR_W-1:(ADDR_W > 16 ? 16 : 0)];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  end else begin : g_addr_narrow
    assign addr_ext = {{(16-ADDR_W){1'b0}}, core_addr};
  end

  assign sel    = decode_port(addr_ext, DIR_ADDR, VAL_ADDR);
  assign wr_dir = (sel == SEL_DIR) && !core_rw;
  assign wr_val = (sel == SEL_VAL) && !core_rw;

  rw_hold_latch u_rw_latch (
    .gate (gate),
    .d    (core_rw),
    .q    (rw_held)
  );

  bus_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus_gate (
    .aec         (aec),
    .core_rw     (core_rw),
    .rw_held     (rw_held),
    .core_addr   (core_addr),
    .core_dout   (core_dout),
    .sys_addr_o  (sys_addr_o),
    .sys_addr_oe (sys_addr_oe),
    .sys_data_o  (sys_data_o),
    .sys_data_oe (sys_data_oe),
    .sys_rw_o    (sys_rw_o),
    .sys_rw_oe   (sys_rw_oe)
  );

  io_port_regs #(.WIDTH(DATA_W), .MASK(PIN_MASK)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_dir  (wr_dir),
    .wr_val  (wr_val),
    .wdata   (core_dout),
    .pin_in  (pin_in),
    .rd_dir  (rd_dir),
    .rd_val  (rd_val),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    if (!core_rw) begin
      core_din = '0;
    end else begin
      unique case (sel)
        SEL_DIR: core_din = rd_dir;
        SEL_VAL: core_din = rd_val;
        default: core_din = sys_data_i;
      endcase
    end
  end
endmodule

// File: rtl/cpu_bus_adapter_sva.sv
module cpu_bus_adapter_sva #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  PIN_MASK = 8'hDF,
  parameter logic [15:0] DIR_ADDR = 16'h0000,
  parameter logic [15:0] VAL_ADDR = 16'h0001
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] core_addr,
  input logic [DATA_W-1:0] core_dout,
  input logic [DATA_W-1:0] core_din,
  input logic              core_rw,
  input logic              aec,
  input logic              gate,
  input logic              sys_addr_oe,
  input logic              sys_data_oe,
  input logic              sys_rw_o,
  input logic              sys_rw_oe,
  input logic [DATA_W-1:0] pin_oe,
  input logic [DATA_W-1:0] pin_out
);
  p_addr_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !aec |-> !sys_addr_oe);

  p_data_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_data_oe |-> (aec && !core_rw));

  p_rw_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (sys_rw_o == core_rw));

  p_rw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && $past(!gate)) |-> $stable(sys_rw_o));

  p_rw_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rw_oe == aec);

  p_dir_load_r6: assert property (@(negedge clk) disable iff (!rst_n)
    (!core_rw && core_addr == ADDR_W'(DIR_ADDR)) |=>
      (pin_oe == ($past(core_dout) & DATA_W'(PIN_MASK))));

  p_val_load_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (!core_rw && core_addr == ADDR_W'(VAL_ADDR)) |=>
      (pin_out == ($past(core_dout) & DATA_W'(PIN_MASK))));

  p_dir_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rw && core_addr == ADDR_W'(DIR_ADDR)) |-> (core_din == pin_oe));

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rw |-> (core_din == '0));
endmodule

bind cpu_bus_adapter cpu_bus_adapter_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_MASK(PIN_MASK),
  .DIR_ADDR(DIR_ADDR), .VAL_ADDR(VAL_ADDR)
) u_sva (
  .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_dout(core_dout),
  .core_din(core_din), .core_rw(core_rw), .aec(aec), .gate(gate),
  .sys_addr_oe(sys_addr_oe), .sys_data_oe(sys_data_oe),
  .sys_rw_o(sys_rw_o), .sys_rw_oe(sys_rw_oe),
  .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/cpu_bus_adapter_bench.sv
`timescale 1ns/100ps
module cpu_bus_adapter_bench;
  localparam logic [7:0] MASK = 8'hDF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] core_addr = '0;
  logic [7:0]  core_dout = '0;
  logic [7:0]  core_din;
  logic        core_rw = 1'b1;
  logic        aec = 1'b1;
  logic        gate = 1'b1;
  logic [15:0] sys_addr_o;
  logic        sys_addr_oe;
  logic [7:0]  sys_data_o;
  logic        sys_data_oe;
  logic [7:0]  sys_data_i = '0;
  logic        sys_rw_o;
  logic        sys_rw_oe;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_bus_adapter u_cpu_bus_adapter (
    .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_dout(core_dout),
    .core_din(core_din), .core_rw(core_rw), .aec(aec), .gate(gate),
    .sys_addr_o(sys_addr_o), .sys_addr_oe(sys_addr_oe),
    .sys_data_o(sys_data_o), .sys_data_oe(sys_data_oe),
    .sys_data_i(sys_data_i), .sys_rw_o(sys_rw_o), .sys_rw_oe(sys_rw_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct {
    logic [51:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  logic [7:0] m_dir = '0;
  logic [7:0] m_val = '0;
  logic       m_rw  = 1'b1;

  function automatic logic [51:0] pack_now();
    return {core_din, sys_addr_o, sys_addr_oe, sys_data_o, sys_data_oe,
            sys_rw_o, sys_rw_oe, pin_out, pin_oe};
  endfunction

  task automatic cycle(input logic [15:0] a, input logic [7:0] d,
                       input logic rw, input logic en, input logic g,
                       input logic [7:0] sdi, input logic [7:0] pin,
                       input string tag);
    item_t it;
    logic [7:0] din_e;
    @(posedge clk);
    #0.5;
    core_addr = a; core_dout = d; core_rw = rw; aec = en; gate = g;
    sys_data_i = sdi; pin_in = pin;
    if (g) m_rw = rw;
    if (!rw)            din_e = 8'h00;
    else if (a == 16'h0000) din_e = m_dir & MASK;
    else if (a == 16'h0001) din_e = ((m_val & m_dir) | (pin & ~m_dir)) & MASK;
    else                din_e = sdi;
    it.exp = {din_e, a, en, d, en & ~rw, m_rw, en, m_val & MASK, m_dir & MASK};
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    #0.5;
    if (!rw && a == 16'h0000) m_dir = d & MASK;
    if (!rw && a == 16'h0001) m_val = d & MASK;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1.5;
      if (sb.size() > 0) begin
        item_t it;
        logic [51:0] act;
        it  = sb.pop_front();
        act = pack_now();
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #0.5;
    checks++;
    if (pin_oe !== 8'h00 || pin_out !== 8'h00) begin
      errors++;
      $display("FAIL R1: actual oe=%h out=%h expected oe=00 out=00", pin_oe, pin_out);
    end
    rst_n = 1'b1;
    // R10 plain reads from system bus
    cycle(16'h1234, 8'h00, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h00, "R10 read other");
    cycle(16'h0002, 8'h00, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h00, "R10 no alias 0002");
    cycle(16'h0100, 8'h00, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hFF, "R10 no alias 0100");
    // R2 R3 R5 bus released with aec low
    cycle(16'h8000, 8'h77, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R2 R3 R5 aec low write");
    cycle(16'h8001, 8'h00, 1'b1, 1'b0, 1'b1, 8'h11, 8'h00, "R2 R5 aec low read");
    cycle(16'h4000, 8'h99, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R3 write drives data");
    // R1 registers read back zero after reset
    cycle(16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, "R1 dir reads zero");
    // R4 latch hold and follow
    cycle(16'h2000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R4 hold read");
    cycle(16'h2001, 8'h42, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R4 hold ignores write");
    cycle(16'h2002, 8'h42, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R4 follow write");
    cycle(16'h2003, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R4 hold write level");
    cycle(16'h2004, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R5 held strobe released");
    // R6 R11 direction write all ones, bit 5 dropped
    cycle(16'h0000, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R6 R11 dir write FF");
    cycle(16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, "R6 R8 dir read");
    // R7 value write
    cycle(16'h0001, 8'hAA, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R7 R11 val write AA");
    cycle(16'h0001, 8'h00, 1'b1, 1'b1, 1'b1, 8'hEE, 8'h55, "R9 all outputs");
    // R9 mixed direction
    cycle(16'h0000, 8'h0F, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R6 dir write 0F");
    cycle(16'h0001, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'hF0, "R9 mixed F0");
    cycle(16'h0001, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, "R9 mixed FF bit5");
    cycle(16'h0001, 8'h55, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R7 val write aec low");
    cycle(16'h0001, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h20, "R9 after 55");
    cycle(16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R6 dir clear");
    cycle(16'h0001, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'hDB, "R9 all inputs");
    cycle(16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, "R8 dir read zero");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule